// File: doc/BRIEF.md
# Posit Bit-Level Operation Unit

This block applies one of a set of cheap operations to raw posit words, chosen each cycle by an opcode. Because posits sort exactly like two's-complement integers, the five comparisons, negation and absolute value reuse plain integer logic. Reciprocal is a bit-level approximation. For the exponent-free format (ES = 0), the complement 1-x and a fast pseudo-sigmoid are also pure bit manipulation. Doubling and halving decode the word partly into sign, regime, exponent and fraction. They move the scale by one step and encode again, with the fraction truncated and never rounded.

One request is accepted on any cycle where `op_valid` is high. The result and the compare flag are registered and appear one cycle later, together with `res_valid`. The word width N and the exponent size ES are parameters. The exception pattern (NaR) is a one in the sign bit followed by all zeros. Zero is the all-zero word. The all-ones word without its sign bit is maxpos, and the word 0…01 is minpos.

Top module: `posit_bitops_unit`

## Requirements
- R1: An operation presented with `op_valid` high at a rising edge appears on `res_word`/`res_flag` after that edge, with `res_valid` high for exactly that cycle. While `res_valid` is low, both outputs keep their last value. Reset clears all three outputs.
- R2: Opcodes 0 to 4 are less, less-or-equal, greater, greater-or-equal and equal. Each treats A and B as signed integers, so NaR sorts below every value and NaR equals NaR. `res_flag` carries the outcome and `res_word` is zero.
- R3: For every opcode from 5 to 15, `res_flag` is 0.
- R4: Opcode 5 (negate) returns the two's complement of A. Zero and NaR map to themselves.
- R5: Opcode 6 (absolute) returns A when its sign bit is clear and the two's complement of A otherwise. NaR stays NaR.
- R6: Opcode 7 (reciprocal) keeps the sign bit and replaces the other N-1 bits by their inverse plus one. Zero and NaR both give NaR.
- R7: Opcode 8 (double) raises the scale (regime·2^ES + exponent) by one. It keeps the sign and the fraction bits that still fit, truncating the rest. It saturates at ±maxpos, and zero and NaR pass through.
- R8: Opcode 9 (halve) lowers the scale by one under the same encoding rules. It never yields zero, so a result below minpos becomes ±minpos.
- R9: With ES = 0, opcode 10 returns the word 2^(N-2) - A when A lies between zero and the word for one (0100…0). It returns NaR for any other A.
- R10: With ES = 0, opcode 11 returns A with its top bit inverted, then shifted right logically by two places.
- R11: Opcodes 12 to 15 return NaR. When ES is not 0, opcodes 10 and 11 also return NaR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Accept the operation this cycle |
| op_code | input | 4 | Operation select (see R2 to R11) |
| opnd_a | input | N | First posit operand |
| opnd_b | input | N | Second posit operand (comparisons only) |
| res_valid | output | 1 | Result registered this cycle |
| res_word | output | N | Posit result |
| res_flag | output | 1 | Comparison outcome |

## Verification
On every cycle, the assertions check the valid timing and the holding of the outputs when no result is due. They also check the zero flag for non-compare opcodes, that a negation sums to zero with its operand, and that an absolute value has a clear sign unless it is NaR. Further cycle checks cover sign preservation and the never-zero, never-NaR outcome of doubling and halving, the zero word on comparisons, and the range of the sigmoid output. Exact values come only from the bench's scenarios. These include regime growth and shrinkage with fraction truncation, saturation at maxpos and minpos, and the ES-dependent opcodes, run against two instances with different exponent sizes across every operand pattern.

// File: rtl/posit_ops_pkg.sv
package posit_ops_pkg;
  typedef enum logic [3:0] {
    OP_LT  = 4'd0,
    OP_LE  = 4'd1,
    OP_GT  = 4'd2,
    OP_GE  = 4'd3,
    OP_EQ  = 4'd4,
    OP_NEG = 4'd5,
    OP_ABS = 4'd6,
    OP_RCP = 4'd7,
    OP_DBL = 4'd8,
    OP_HLF = 4'd9,
    OP_OMX = 4'd10,
    OP_SIG = 4'd11
  } posit_op_e;

  function automatic logic op_is_cmp(input logic [3:0] code);
    return code <= 4'd4;
  endfunction
endpackage

// File: rtl/posit_cmp_unit.sv
module posit_cmp_unit
  import posit_ops_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic [3:0]   code,
  output logic         flag
);
  logic lt, eq;

  always_comb begin
    lt = $signed(a) < $signed(b);
    eq = (a == b);
    case (code)
      OP_LT:   flag = lt;
      OP_LE:   flag = lt | eq;
      OP_GT:   flag = ~(lt | eq);
      OP_GE:   flag = ~lt;
      OP_EQ:   flag = eq;
      default: flag = 1'b0;
    endcase
  end
endmodule

// File: rtl/posit_word_unit.sv
module posit_word_unit
  import posit_ops_pkg::*;
#(
  parameter int N  = 8,
  parameter int ES = 0
) (
  input  logic [N-1:0] a,
  input  logic [3:0]   code,
  output logic [N-1:0] y
);
  localparam logic [N-1:0] NAR = {1'b1, {(N-1){1'b0}}};
  localparam logic [N-1:0] ONE = {2'b01, {(N-2){1'b0}}};

  logic [N-1:0] neg_w, abs_w, rcp_w, omx_w, sig_w;

  always_comb begin
    neg_w = ~a + 1'b1;
    abs_w = a[N-1] ? neg_w : a;
    if (a[N-2:0] == '0) rcp_w = NAR;
    else                rcp_w = {a[N-1], (N-1)'(~a[N-2:0] + 1'b1)};
  end

  generate
    if (ES == 0) begin : g_es0
      always_comb begin
        if (!a[N-1] && (a <= ONE)) omx_w = ONE - a;
        else                       omx_w = NAR;
        sig_w = {~a[N-1], a[N-2:0]} >> 2;
      end
    end else begin : g_esn
      always_comb begin
        omx_w = NAR;
        sig_w = NAR;
      end
    end
  endgenerate

  always_comb begin
    case (code)
      OP_NEG:  y = neg_w;
      OP_ABS:  y = abs_w;
      OP_RCP:  y = rcp_w;
      OP_OMX:  y = omx_w;
      OP_SIG:  y = sig_w;
      default: y = NAR;
    endcase
  end
endmodule

// File: rtl/posit_scale_unit.sv
module posit_scale_unit #(
  parameter int N  = 8,
  parameter int ES = 0
) (
  input  logic [N-1:0] a,
  input  logic         up,
  output logic [N-1:0] y
);
  localparam int MW = N - 1;
  localparam int FW = N - 1 - ES;
  localparam logic [N-1:0] NAR = {1'b1, {(N-1){1'b0}}};
  localparam logic [MW-1:0] FMASK = MW'((1 << FW) - 1);

  logic          sgn, first, stop;
  logic [MW-1:0] x, body, tail, mag_new;
  logic [N-1:0]  pos;
  logic signed [N:0] z;
  int run, k, ex, sc, k2, e2, sh;

  always_comb begin
    sgn   = a[N-1];
    x     = MW'(sgn ? (~a + 1'b1) : a);
    first = x[MW-1];
    run   = 0;
    stop  = 1'b0;
    for (int i = MW - 1; i >= 0; i--) begin
      if (!stop && (x[i] == first)) run = run + 1;
      else                          stop = 1'b1;
    end
    k    = first ? run - 1 : -run;
    body = (run + 1 >= MW) ? '0 : (x << (run + 1));
    ex   = int'(body >> FW);
    sc   = k * (1 << ES) + ex + (up ? 1 : -1);
    k2   = sc >>> ES;
    e2   = sc - k2 * (1 << ES);
    tail = (MW'(e2) << FW) | (body & FMASK);
    sh   = (k2 >= 0) ? k2 : -k2 - 1;
    if (sh > N) sh = N;
    z       = {((k2 >= 0) ? 2'b10 : 2'b01), tail};
    mag_new = MW'(z >>> (sh + 2));
    if (mag_new == '0) mag_new = MW'(1);
    pos = {1'b0, mag_new};
    if ((a == '0) || (a == NAR)) y = a;
    else if (sgn)                y = ~pos + 1'b1;
    else                         y = pos;
  end
endmodule

// File: rtl/posit_bitops_unit.sv
module posit_bitops_unit
  import posit_ops_pkg::*;
#(
  parameter int N  = 8,
  parameter int ES = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_valid,
  input  logic [3:0]   op_code,
  input  logic [N-1:0] opnd_a,
  input  logic [N-1:0] opnd_b,
  output logic         res_valid,
  output logic [N-1:0] res_word,
  output logic         res_flag
);
  logic         cmp_flag;
  logic [N-1:0] word_y, scale_y;
  logic [N-1:0] res_d;
  logic         flag_d;

  posit_cmp_unit #(.N(N)) u_cmp (
    .a(opnd_a), .b(opnd_b), .code(op_code), .flag(cmp_flag)
  );

  posit_word_unit #(.N(N), .ES(ES)) u_word (
    .a(opnd_a), .code(op_code), .y(word_y)
  );

  posit_scale_unit #(.N(N), .ES(ES)) u_scale (
    .a(opnd_a), .up(op_code != OP_HLF), .y(scale_y)
  );

  always_comb begin
    if (op_is_cmp(op_code)) begin
      res_d  = '0;
      flag_d = cmp_flag;
    end else if ((op_code == OP_DBL) || (op_code == OP_HLF)) begin
      res_d  = scale_y;
      flag_d = 1'b0;
    end else begin
      res_d  = word_y;
      flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_word  <= '0;
      res_flag  <= 1'b0;
    end else begin
      res_valid <= op_valid;
      if (op_valid) begin
        res_word <= res_d;
        res_flag <= flag_d;
      end
    end
  end
endmodule

// File: rtl/posit_bitops_chk.sv
module posit_bitops_chk
  import posit_ops_pkg::*;
#(
  parameter int N  = 8,
  parameter int ES = 0
) (
  input logic         clk,
  input logic         rst_n,
  input logic         op_valid,
  input logic [3:0]   op_code,
  input logic [N-1:0] opnd_a,
  input logic         res_valid,
  input logic [N-1:0] res_word,
  input logic         res_flag
);
  localparam logic [N-1:0] NAR = {1'b1, {(N-1){1'b0}}};

  assert_valid_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid == ($past(op_valid) && $past(rst_n)));

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> ($stable(res_word) && $stable(res_flag)));

  assert_cmp_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && ($past(op_code) <= 4'd4)) |-> (res_word == '0));

  assert_flag_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && ($past(op_code) > 4'd4)) |-> !res_flag);

  assert_neg_sum_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && ($past(op_code) == OP_NEG)) |-> (N'(res_word + $past(opnd_a)) == '0));

  assert_abs_sign_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && ($past(op_code) == OP_ABS)) |-> (!res_word[N-1] || (res_word == NAR)));

  // covers R7 and R8
  assert_scale_sign_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && (($past(op_code) == OP_DBL) || ($past(op_code) == OP_HLF)) &&
     ($past(opnd_a) != '0) && ($past(opnd_a) != NAR))
    |-> ((res_word != '0) && (res_word != NAR) && (res_word[N-1] == $past(opnd_a[N-1]))));

  assert_sig_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((ES == 0) && res_valid && ($past(op_code) == OP_SIG)) |-> (res_word[N-1:N-2] == 2'b00));
endmodule

bind posit_bitops_unit posit_bitops_chk #(.N(N), .ES(ES)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
  .opnd_a(opnd_a), .res_valid(res_valid), .res_word(res_word), .res_flag(res_flag)
);

// File: tb/tb_posit_bitops_unit.sv
module tb_posit_bitops_unit;
  localparam int W = 8;

  typedef struct {
    logic [8:0] e0;
    logic [8:0] e1;
    string      tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_n;
  logic op_valid;
  logic [3:0] op_code;
  logic [W-1:0] a_i, b_i;
  logic v0, v1, f0, f1;
  logic [W-1:0] r0, r1;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  item_t q[$];
  logic [8:0] last0, last1;

  always #10 clk = ~clk;

  posit_bitops_unit #(.N(W), .ES(0)) dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .opnd_a(a_i), .opnd_b(b_i), .res_valid(v0), .res_word(r0), .res_flag(f0)
  );

  posit_bitops_unit #(.N(W), .ES(1)) dut_e1 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .opnd_a(a_i), .opnd_b(b_i), .res_valid(v1), .res_word(r1), .res_flag(f1)
  );

  function automatic logic [7:0] m_scale(int es, logic [7:0] a, int d);
    logic [7:0] m;
    logic [6:0] x, o;
    logic first;
    int i, run, k, e, s, k2, e2, p;
    if (a == 8'h00 || a == 8'h80) return a;
    m = a[7] ? 8'(-a) : a;
    x = m[6:0];
    first = x[6];
    i = 6;
    run = 0;
    while (i >= 0 && x[i] == first) begin run++; i--; end
    k = first ? run - 1 : -run;
    i--;
    e = 0;
    for (int j = 0; j < es; j++) begin
      e = e * 2 + ((i >= 0) ? int'(x[i]) : 0);
      i--;
    end
    s = k * (1 << es) + e + d;
    k2 = s >>> es;
    e2 = s - k2 * (1 << es);
    o = '0;
    p = 6;
    if (k2 >= 0) begin
      for (int j = 0; j <= k2; j++) begin if (p >= 0) o[p] = 1'b1; p--; end
      p--;
    end else begin
      p = p + k2;
      if (p >= 0) o[p] = 1'b1;
      p--;
    end
    for (int j = 0; j < es; j++) begin
      if (p >= 0) o[p] = 1'((e2 >> (es - 1 - j)) & 1);
      p--;
    end
    for (int t = i; t >= 0; t--) begin
      if (p >= 0) o[p] = x[t];
      p--;
    end
    if (o == '0) o = 7'd1;
    return a[7] ? 8'(-{1'b0, o}) : {1'b0, o};
  endfunction

  // returns {flag, word}
  function automatic logic [8:0] model(int es, logic [3:0] op, logic [7:0] a, logic [7:0] b);
    logic signed [7:0] sa, sb;
    sa = a;
    sb = b;
    case (op)
      4'd0: return {sa < sb, 8'h00};
      4'd1: return {sa <= sb, 8'h00};
      4'd2: return {sa > sb, 8'h00};
      4'd3: return {sa >= sb, 8'h00};
      4'd4: return {a == b, 8'h00};
      4'd5: return {1'b0, 8'(-a)};
      4'd6: return {1'b0, a[7] ? 8'(-a) : a};
      4'd7: return (a[6:0] == 7'd0) ? 9'h080 : {1'b0, a[7], 7'(~a[6:0] + 7'd1)};
      4'd8: return {1'b0, m_scale(es, a, 1)};
      4'd9: return {1'b0, m_scale(es, a, -1)};
      4'd10: begin
        if (es != 0) return 9'h080;
        return (sa >= 0 && a <= 8'h40) ? {1'b0, 8'(8'h40 - a)} : 9'h080;
      end
      4'd11: begin
        if (es != 0) return 9'h080;
        return {1'b0, 8'({~a[7], a[6:0]} >> 2)};
      end
      default: return 9'h080;
    endcase
  endfunction

  function automatic string req_of(logic [3:0] op);
    case (op)
      4'd0, 4'd1, 4'd2, 4'd3, 4'd4: return "R2";
      4'd5: return "R4";
      4'd6: return "R5";
      4'd7: return "R6";
      4'd8: return "R7";
      4'd9: return "R8";
      4'd10: return "R9";
      4'd11: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic check(string tag, logic [8:0] got, logic [8:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got flag/word %h expected %h", tag, got, exp);
    end
  endtask

  task automatic drive(logic [3:0] op, logic [7:0] a, logic [7:0] b, string tag);
    item_t it;
    @(negedge clk);
    op_valid = 1'b1;
    op_code  = op;
    a_i      = a;
    b_i      = b;
    it.e0  = model(0, op, a, b);
    it.e1  = model(1, op, a, b);
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic idle(int n);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      op_valid = 1'b0;
      a_i = 8'hA5;
      op_code = 4'd5;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (v0 || v1) begin
        if (q.size() == 0) begin
          check("R1 unexpected result", 9'h1FF, 9'h000);
        end else begin
          item_t it;
          it = q.pop_front();
          check({it.tag, " es0"}, {f0, r0}, it.e0);
          check({it.tag, " es1"}, {f1, r1}, it.e1);
          check("R1 valid pair", {8'h00, v0 & v1}, 9'h001);
        end
      end else begin
        check("R1 hold es0", {f0, r0}, last0);
        check("R1 hold es1", {f1, r1}, last1);
      end
      last0 = {f0, r0};
      last1 = {f1, r1};
    end
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    op_valid = 1'b0;
    op_code = 4'd0;
    a_i = '0;
    b_i = '0;
    last0 = '0;
    last1 = '0;
    repeat (3) @(negedge clk);
    check("R1 reset es0", {v0, f0, r0} == 10'd0 ? 9'd0 : 9'd1, 9'd0);
    check("R1 reset es1", {v1, f1, r1} == 10'd0 ? 9'd0 : 9'd1, 9'd0);
    rst_n = 1'b1;

    // hand-picked corners
    drive(4'd0, 8'h80, 8'h81, "R2 NaR lowest");
    drive(4'd4, 8'h80, 8'h80, "R2 NaR equal");
    drive(4'd3, 8'h7F, 8'h7F, "R2 ge equal");
    drive(4'd5, 8'h80, 8'h00, "R4 neg NaR");
    drive(4'd6, 8'hC0, 8'h00, "R5 abs neg one");
    drive(4'd7, 8'h00, 8'h00, "R6 rcp zero");
    drive(4'd7, 8'h40, 8'h00, "R6 rcp one");
    drive(4'd8, 8'h7F, 8'h00, "R7 dbl maxpos");
    drive(4'd8, 8'h40, 8'h00, "R7 dbl one");
    drive(4'd9, 8'h01, 8'h00, "R8 hlf minpos");
    drive(4'd9, 8'hC0, 8'h00, "R8 hlf neg one");
    drive(4'd10, 8'h20, 8'h00, "R9 omx half");
    drive(4'd10, 8'h41, 8'h00, "R9 omx above one");
    drive(4'd11, 8'h00, 8'h00, "R10 sig zero");
    drive(4'd13, 8'h40, 8'h40, "R11 undefined op");
    idle(3);
    drive(4'd8, 8'h80, 8'h00, "R7 dbl NaR");
    drive(4'd9, 8'h00, 8'h00, "R8 hlf zero");
    idle(2);

    // exhaustive operand sweep for every opcode, R3 flag covered by model
    for (int op = 0; op < 16; op++) begin
      for (int a = 0; a < 256; a++) begin
        logic [7:0] bb;
        bb = (a % 5 == 0) ? 8'(a) : 8'(a * 37 + 11);
        drive(4'(op), 8'(a), bb, {req_of(4'(op)), " R3 sweep"});
        if (a % 64 == 63) idle(2);
      end
    end
    idle(4);
    check("R1 queue drained", 9'(q.size()), 9'd0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule